// File: doc/BRIEF.md
# Even/Odd Wavefront Interleaving Sequencer

This block paces two wavefront slots, even and odd, through one operand-read stage and one execute stage shared by both. Every ALU instruction of a wavefront occupies a read window of four cycles, one quarter-wavefront per cycle, and then an execute window of four cycles, again one quarter per cycle. The even slot owns the read stage in the first half of a free-running eight-cycle frame and the odd slot owns it in the second half. While one slot reads, the other executes. Back-to-back instructions of one wavefront are therefore eight cycles apart, and neither stage goes idle as long as both slots have work.

A wavefront is loaded into a slot together with its instruction count. The slot then issues one instruction per frame until the count is used up. The slot frees itself in the last execute quarter of its final instruction, and a new wavefront may be loaded in that same cycle. A stalled slot, an empty slot and a slot that is waiting out a clause switch all leave their window as a bubble. The other slot never takes that window. Each cycle the block reports, for each stage, a valid flag, the slot index and the quarter index. The datapath itself is outside this block.

Top module: `wave_interleave_seq`

## Requirements
- R1: After reset both stages are invalid, `wf_done_o` is 0, `load_ready_o` is 2'b11, and the frame starts at position 0: `rd_slot_o`=0 and `rd_quarter_o`=0.
- R2: Frame position p counts 0..7 and starts at 0 in the first cycle after reset. The read stage belongs to slot 0 (even) for p=0..3 and to slot 1 (odd) for p=4..7. A granted read window shows `rd_valid_o`=1 for four consecutive cycles with `rd_quarter_o` = p mod 4.
- R3: Each read window is followed directly by an execute window of the same slot, four cycles with `ex_valid_o`=1 and `ex_quarter_o` running 0..3.
- R4: When both stages are valid, they never carry the same slot.
- R5: A wavefront loaded with count N (N ≥ 1) performs exactly N reads, one in each of its own successive windows. `wf_done_o[slot]` pulses in the last execute quarter of its N-th instruction.
- R6: A load (`wf_load_i`=1, target `wf_slot_i`, count `wf_ninstr_i`) is accepted only when `load_ready_o[slot]`=1 and the count is nonzero. A load into a busy slot, or a load with count 0, has no effect.
- R7: A wavefront loaded in the same cycle as the retire pulse of the previous one is accepted. Its slot's next window is a bubble, and its first read comes one frame later.
- R8: If `slot_stall_i[s]` is high in the last cycle before slot s's read window, that window is a bubble. The other slot keeps its own windows and phase.
- R9: A pulse on `clause_sw_i[s]` blocks reads by slot s until SWITCH_CYCLES+1 clock edges have passed. A read window can be granted only at a window boundary at which the count has run out.
- R10: `load_ready_o[s]` is high when slot s is empty or is retiring in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wf_load_i | input | 1 | Load request for a new wavefront |
| wf_slot_i | input | 1 | Target slot of the load (0 even, 1 odd) |
| wf_ninstr_i | input | INSTR_W | Number of instructions of the loaded wavefront |
| slot_stall_i | input | 2 | Per-slot stall, sampled at the end of the window before the slot's read window |
| clause_sw_i | input | 2 | Per-slot clause switch pulse |
| load_ready_o | output | 2 | Slot can accept a wavefront this cycle |
| wf_done_o | output | 2 | Per-slot retire pulse in the last execute quarter |
| rd_valid_o | output | 1 | Read stage busy this cycle |
| rd_slot_o | output | 1 | Slot owning the read stage |
| rd_quarter_o | output | QW | Quarter being read |
| ex_valid_o | output | 1 | Execute stage busy this cycle |
| ex_slot_o | output | 1 | Slot owning the execute stage |
| ex_quarter_o | output | QW | Quarter being executed |

## Verification
Two events can fall in the same cycle: a slot retiring its last instruction and a new wavefront being loaded into that same slot. The bench provokes this by driving the load in exactly the cycle in which `wf_done_o` pulses. It then judges whether the load was accepted, whether the slot's next window stays a bubble, and whether the new wavefront reads and retires one frame later. Two further cases are checked at the ports: a load into a busy slot must not shorten or lengthen the running wavefront, and a stalled odd slot must not draw the even slot out of its phase.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  localparam int NUM_SLOTS = 2;
  typedef logic [NUM_SLOTS-1:0] slot_vec_t;
  typedef enum logic {SLOT_EVEN = 1'b0, SLOT_ODD = 1'b1} slot_e;
endpackage

// File: rtl/wfi_frame_ctr.sv
module wfi_frame_ctr #(
  parameter int QUARTERS = 4,
  parameter int QW       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [QW-1:0] quarter_o,
  output logic          half_o,
  output logic          win_end_o
);
  logic [QW-1:0] q_q;
  logic          half_q;

  assign win_end_o = (q_q == QW'(QUARTERS-1));
  assign quarter_o = q_q;
  assign half_o    = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      half_q <= 1'b0;
    end else if (win_end_o) begin
      q_q    <= '0;
      half_q <= ~half_q;
    end else begin
      q_q    <= q_q + 1'b1;
    end
  end
endmodule

// File: rtl/wfi_slot.sv
module wfi_slot #(
  parameter int INSTR_W       = 8,
  parameter int SWITCH_CYCLES = 40,
  parameter int SW_W          = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INSTR_W-1:0] ninstr_i,
  input  logic               grant_i,
  input  logic               retire_i,
  input  logic               clause_sw_i,
  output logic               busy_o,
  output logic               eligible_o,
  output logic               rem_zero_o
);
  logic               busy_q;
  logic [INSTR_W-1:0] rem_q;
  logic [SW_W-1:0]    sw_q;

  assign busy_o     = busy_q;
  assign rem_zero_o = (rem_q == '0);
  assign eligible_o = busy_q && !rem_zero_o && (sw_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      rem_q  <= ninstr_i;
    end else begin
      if (retire_i) busy_q <= 1'b0;
      if (grant_i)  rem_q  <= rem_q - 1'b1;
    end
  end

  // clause switch: no issue until the count drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sw_q <= '0;
    else if (clause_sw_i)   sw_q <= SW_W'(SWITCH_CYCLES);
    else if (sw_q != '0)    sw_q <= sw_q - 1'b1;
  end
endmodule

// File: rtl/wfi_issue_pipe.sv
module wfi_issue_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  logic grant_any_i,
  output logic rd_act_o,
  output logic ex_act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_o <= 1'b0;
      ex_act_o <= 1'b0;
    end else if (win_end_i) begin
      rd_act_o <= grant_any_i;
      ex_act_o <= rd_act_o;
    end
  end
endmodule

// File: rtl/wave_interleave_seq.sv
module wave_interleave_seq #(
  parameter int QUARTERS      = 4,
  parameter int INSTR_W       = 8,
  parameter int SWITCH_CYCLES = 40,
  localparam int QW   = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
  localparam int SW_W = $clog2(SWITCH_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wf_load_i,
  input  logic               wf_slot_i,
  input  logic [INSTR_W-1:0] wf_ninstr_i,
  input  logic [1:0]         slot_stall_i,
  input  logic [1:0]         clause_sw_i,
  output logic [1:0]         load_ready_o,
  output logic [1:0]         wf_done_o,
  output logic               rd_valid_o,
  output logic               rd_slot_o,
  output logic [QW-1:0]      rd_quarter_o,
  output logic               ex_valid_o,
  output logic               ex_slot_o,
  output logic [QW-1:0]      ex_quarter_o
);
  import wfi_pkg::*;

  logic [QW-1:0] quarter;
  logic          half;
  logic          win_end;
  logic          rd_act;
  logic          ex_act;
  logic          next_rd_slot;
  slot_vec_t     busy, eligible, rem_zero, grant, retire, load_acc;

  wfi_frame_ctr #(.QUARTERS(QUARTERS), .QW(QW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .quarter_o (quarter),
    .half_o    (half),
    .win_end_o (win_end)
  );

  // slot owning the next read window is the one executing now
  assign next_rd_slot = ~half;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign grant[s]  = win_end && (next_rd_slot == 1'(s)) && eligible[s] && !slot_stall_i[s];
    assign retire[s] = win_end && ex_act && (ex_slot_o == 1'(s)) && rem_zero[s];
    assign load_ready_o[s] = !busy[s] || retire[s];
    assign load_acc[s] = wf_load_i && (wf_slot_i == 1'(s)) && load_ready_o[s]
                         && (wf_ninstr_i != '0);

    wfi_slot #(.INSTR_W(INSTR_W), .SWITCH_CYCLES(SWITCH_CYCLES), .SW_W(SW_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_acc[s]),
      .ninstr_i    (wf_ninstr_i),
      .grant_i     (grant[s]),
      .retire_i    (retire[s]),
      .clause_sw_i (clause_sw_i[s]),
      .busy_o      (busy[s]),
      .eligible_o  (eligible[s]),
      .rem_zero_o  (rem_zero[s])
    );
  end

  wfi_issue_pipe u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_end_i   (win_end),
    .grant_any_i (|grant),
    .rd_act_o    (rd_act),
    .ex_act_o    (ex_act)
  );

  assign wf_done_o    = retire;
  assign rd_valid_o   = rd_act;
  assign rd_slot_o    = half;
  assign rd_quarter_o = quarter;
  assign ex_valid_o   = ex_act;
  assign ex_slot_o    = ~half;
  assign ex_quarter_o = quarter;
endmodule

// File: rtl/wave_interleave_seq_chk.sv
module wave_interleave_seq_chk #(
  parameter int QUARTERS = 4,
  parameter int QW       = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    load_ready_o,
  input logic [1:0]    wf_done_o,
  input logic          rd_valid_o,
  input logic          rd_slot_o,
  input logic [QW-1:0] rd_quarter_o,
  input logic          ex_valid_o,
  input logic          ex_slot_o,
  input logic [QW-1:0] ex_quarter_o
);
  p_rd_quarter_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_quarter_o != QW'(QUARTERS-1)) |=>
      (rd_valid_o && rd_quarter_o == QW'($past(rd_quarter_o) + 1'b1)
       && rd_slot_o == $past(rd_slot_o)));

  p_ex_follows_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_quarter_o == QW'(QUARTERS-1)) |=>
      (ex_valid_o && ex_slot_o == $past(rd_slot_o) && ex_quarter_o == '0));

  p_slot_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && ex_valid_o) |-> (rd_slot_o != ex_slot_o));

  p_done_last_quarter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wf_done_o) |-> (ex_valid_o && ex_quarter_o == QW'(QUARTERS-1)
                      && $onehot0(wf_done_o) && wf_done_o[ex_slot_o]));

  p_done_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wf_done_o) |-> ((wf_done_o & load_ready_o) == wf_done_o));
endmodule

bind wave_interleave_seq wave_interleave_seq_chk #(.QUARTERS(QUARTERS), .QW(QW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_ready_o (load_ready_o),
  .wf_done_o    (wf_done_o),
  .rd_valid_o   (rd_valid_o),
  .rd_slot_o    (rd_slot_o),
  .rd_quarter_o (rd_quarter_o),
  .ex_valid_o   (ex_valid_o),
  .ex_slot_o    (ex_slot_o),
  .ex_quarter_o (ex_quarter_o)
);

// File: tb/tb_wave_interleave_seq.sv
module tb_wave_interleave_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wf_load_i = 1'b0;
  logic       wf_slot_i = 1'b0;
  logic [7:0] wf_ninstr_i = '0;
  logic [1:0] slot_stall_i = '0;
  logic [1:0] clause_sw_i = '0;
  logic [1:0] load_ready_o, wf_done_o;
  logic       rd_valid_o, rd_slot_o, ex_valid_o, ex_slot_o;
  logic [1:0] rd_quarter_o, ex_quarter_o;

  int checks = 0;
  int errors = 0;
  int fpos = 0;
  bit finished = 1'b0;

  wave_interleave_seq dut (.*);

  always #4 clk_i = ~clk_i;

  // frame position per R2, counted independently
  always @(posedge clk_i) if (rst_ni) fpos = (fpos + 1) % 8;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pos(input int k);
    while (fpos != k) @(negedge clk_i);
  endtask

  task automatic load(input logic s, input int n);
    wf_load_i = 1'b1; wf_slot_i = s; wf_ninstr_i = 8'(n);
    @(negedge clk_i);
    wf_load_i = 1'b0;
  endtask

  // one four-cycle window starting at a window boundary
  task automatic check_win(input logic rv, input logic rs, input logic ev, input logic es,
                           input logic [1:0] dn, input string tag);
    for (int q = 0; q < 4; q++) begin
      chk({tag, " rd_valid"}, rd_valid_o, rv);
      if (rv) begin
        chk({tag, " rd_slot"}, rd_slot_o, rs);
        chk({tag, " rd_quarter"}, rd_quarter_o, q);
      end
      chk({tag, " ex_valid"}, ex_valid_o, ev);
      if (ev) begin
        chk({tag, " ex_slot"}, ex_slot_o, es);
        chk({tag, " ex_quarter"}, ex_quarter_o, q);
      end
      chk({tag, " done"}, wf_done_o, (q == 3) ? dn : 2'b00);
      if (q == 3 && dn != 0) chk({tag, " ready R10"}, int'(load_ready_o & dn), dn);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 ex_valid", ex_valid_o, 0);
    chk("R1 ready", load_ready_o, 3);
    chk("R1 done", wf_done_o, 0);
    chk("R1 rd_slot", rd_slot_o, 0);
    chk("R1 rd_quarter", rd_quarter_o, 0);
  endtask

  task automatic t_single;
    wait_pos(0);
    load(1'b0, 2);
    wait_pos(0);
    check_win(1, 0, 0, 0, 2'b00, "R2 single w0");
    check_win(0, 1, 1, 0, 2'b00, "R3 single w1");
    check_win(1, 0, 0, 0, 2'b00, "R5 single w2");
    check_win(0, 1, 1, 0, 2'b01, "R5 single w3");
    check_win(0, 0, 0, 1, 2'b00, "R5 single idle");
  endtask

  task automatic t_interleave;
    wait_pos(0);
    load(1'b0, 3);
    load(1'b1, 3);
    wait_pos(4);
    check_win(1, 1, 0, 0, 2'b00, "R2 il w0");
    check_win(1, 0, 1, 1, 2'b00, "R4 il w1");
    check_win(1, 1, 1, 0, 2'b00, "R4 il w2");
    check_win(1, 0, 1, 1, 2'b00, "R4 il w3");
    check_win(1, 1, 1, 0, 2'b00, "R4 il w4");
    check_win(1, 0, 1, 1, 2'b10, "R5 il w5");
    check_win(0, 1, 1, 0, 2'b01, "R5 il w6");
    check_win(0, 0, 0, 1, 2'b00, "R5 il w7");
  endtask

  task automatic t_stall;
    wait_pos(0);
    load(1'b0, 2);
    load(1'b1, 2);
    slot_stall_i = 2'b10;
    wait_pos(4);
    slot_stall_i = 2'b00;
    check_win(0, 1, 0, 0, 2'b00, "R8 st w0");
    check_win(1, 0, 0, 1, 2'b00, "R8 st w1");
    check_win(1, 1, 1, 0, 2'b00, "R8 st w2");
    check_win(1, 0, 1, 1, 2'b00, "R8 st w3");
    check_win(1, 1, 1, 0, 2'b01, "R8 st w4");
    check_win(0, 0, 1, 1, 2'b10, "R8 st w5");
  endtask

  task automatic t_retire_load;
    wait_pos(0);
    load(1'b1, 0);
    chk("R6 zero count ready", load_ready_o[1], 1);
    load(1'b0, 1);
    chk("R6 busy ready", load_ready_o[0], 0);
    load(1'b0, 5);
    wait_pos(0);
    check_win(1, 0, 0, 0, 2'b00, "R6 rl w0");
    for (int q = 0; q < 4; q++) begin
      chk("R6 rl ex_valid", ex_valid_o, 1);
      chk("R6 rl done", wf_done_o, (q == 3) ? 1 : 0);
      if (q == 3) begin
        chk("R7 ready at retire", load_ready_o[0], 1);
        load(1'b0, 1);
      end else begin
        @(negedge clk_i);
      end
    end
    check_win(0, 0, 0, 1, 2'b00, "R7 rl bubble");
    check_win(0, 1, 0, 0, 2'b00, "R6 odd zero-count bubble");
    check_win(1, 0, 0, 1, 2'b00, "R7 rl reread");
    check_win(0, 1, 1, 0, 2'b01, "R7 rl redone");
  endtask

  task automatic t_switch;
    wait_pos(0);
    clause_sw_i = 2'b01;
    load(1'b0, 1);
    clause_sw_i = 2'b00;
    wait_pos(0);
    for (int w = 0; w < 10; w++) check_win(0, 0, 0, 0, 2'b00, "R9 sw bubble");
    check_win(1, 0, 0, 0, 2'b00, "R9 sw read");
    check_win(0, 1, 1, 0, 2'b01, "R9 sw done");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_interleave();
    t_stall();
    t_retire_load();
    t_switch();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule